// File: doc/BRIEF.md
# Burst Read Capture with WAIT-Aligned Qualification

This block sits on the controller side of a synchronous burst memory port. It samples the memory's active-high WAIT line on the rising clock edge. From it the block builds a qualifier that marks which beats of the 16-bit read bus carry good data. Each good beat comes out as a captured word with a one-cycle valid strobe. After the last word of the burst, a one-cycle done pulse follows.

A mode input selects how WAIT relates to the data bus. In the same-edge mode, a beat is good when WAIT is low in that same cycle. In the lead mode, WAIT moves one clock ahead of the data, so a beat is good when WAIT was low in the cycle before it. The mode is taken when a burst starts and does not change until that burst ends. A burst begins with a one-cycle start request that carries the word count minus one. The burst ends once that many words have been captured. Command issue, initial latency, writes and driver settings belong to other blocks.

Top module: `burst_wait_capture`

## Requirements
- R1: While rst_n is low, and after it is released, cap_valid_o and done_o are 0 and no burst is active.
- R2: With the latched mode at 0, the bus word present in cycle c is captured exactly when wait_i is 0 in cycle c. The word appears on cap_data_o with cap_valid_o high two rising edges after it was driven.
- R3: With the latched mode at 1, the bus word present in cycle c is captured exactly when wait_i was 0 in cycle c-1. It appears with the same two-edge latency.
- R4: When WAIT rises in the middle of a burst, capture stops. It resumes when WAIT falls, with no word lost, repeated or reordered.
- R5: A burst delivers exactly len_m1_i+1 strobes, covering every count from 1 up to MAX_WORDS (256 by default). The bus word of the cycle in which start_i is sampled is eligible for capture.
- R6: done_o is high for exactly one cycle, in the cycle right after the strobe of the final word.
- R7: A start_i pulse that arrives while a burst is active has no effect on that burst's length or mode.
- R8: cfg_late_i is sampled only together with an accepted start. Changing it during a burst does not change that burst's capture timing.
- R9: With no burst active, no strobe is produced, whatever wait_i and dq_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle burst start request |
| len_m1_i | input | $clog2(MAX_WORDS) | Word count minus one, taken with start_i |
| cfg_late_i | input | 1 | 0: data good in the same cycle as WAIT low; 1: one cycle after |
| wait_i | input | 1 | Memory WAIT line, active high |
| dq_i | input | DATA_W | Read data bus |
| cap_valid_o | output | 1 | Captured-word strobe |
| cap_data_o | output | DATA_W | Captured word |
| done_o | output | 1 | One-cycle pulse after the final word |

## Verification
The bench uses the default build: DATA_W of 16 and MAX_WORDS of 256. With these values, the full 256-word burst and the single-word burst can both be reached, so the 9-bit remaining count is exercised at both ends. The bench checks every cycle of each burst against a cycle model computed from the WAIT pattern it drives. This covers steady streams, WAIT patterns that stall the burst at irregular points, a start pulse that must be ignored during a burst, and a mode flip in the middle of a burst.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic {
    MODE_SAME = 1'b0,
    MODE_LEAD = 1'b1
  } wait_mode_e;

endpackage

// File: rtl/bwc_wait_align.sv
module bwc_wait_align
  import bwc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] dq_i,
  input  wait_mode_e        mode_i,
  output logic              qual_o,
  output logic [DATA_W-1:0] data_o
);

  logic              wait_s1_q, wait_s2_q;
  logic              wait_s1_d, wait_s2_d;
  logic [DATA_W-1:0] dq_q, dq_d;

  always_comb begin
    wait_s1_d = wait_i;
    wait_s2_d = wait_s1_q;
    dq_d      = dq_i;
  end

  // WAIT history resets to asserted so nothing qualifies from stale state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_s1_q <= 1'b1;
      wait_s2_q <= 1'b1;
      dq_q      <= '0;
    end else begin
      wait_s1_q <= wait_s1_d;
      wait_s2_q <= wait_s2_d;
      dq_q      <= dq_d;
    end
  end

  always_comb begin
    if (mode_i == MODE_LEAD) qual_o = ~wait_s2_q;
    else                     qual_o = ~wait_s1_q;
  end

  assign data_o = dq_q;

  // R3
  lead_mode_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_LEAD && qual_o) |-> $past(!wait_s1_q));

endmodule

// File: rtl/bwc_burst_ctrl.sv
module bwc_burst_ctrl
  import bwc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [$clog2(MAX_WORDS)-1:0] len_m1_i,
  input  logic                         cfg_late_i,
  input  logic                         qual_i,
  input  logic [DATA_W-1:0]            data_i,
  output wait_mode_e                   mode_o,
  output logic                         cap_valid_o,
  output logic [DATA_W-1:0]            cap_data_o,
  output logic                         done_o
);

  localparam int LEN_W = $clog2(MAX_WORDS);
  localparam int REM_W = LEN_W + 1;

  logic              busy_q, busy_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  wait_mode_e        mode_q, mode_d;
  logic              capv_q, capv_d;
  logic [DATA_W-1:0] capd_q;
  logic              last_q, last_d;
  logic              done_q, done_d;
  logic              accept, take;

  assign accept = start_i & ~busy_q;
  assign take   = busy_q & qual_i;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    mode_d = mode_q;
    capv_d = 1'b0;
    last_d = 1'b0;
    done_d = last_q;
    if (accept) begin
      busy_d = 1'b1;
      rem_d  = {1'b0, len_m1_i} + REM_W'(1);
      mode_d = cfg_late_i ? MODE_LEAD : MODE_SAME;
    end else if (take) begin
      capv_d = 1'b1;
      rem_d  = rem_q - REM_W'(1);
      if (rem_q == REM_W'(1)) begin
        busy_d = 1'b0;
        last_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      mode_q <= MODE_LEAD;
      capv_q <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      mode_q <= mode_d;
      capv_q <= capv_d;
      last_q <= last_d;
      done_q <= done_d;
    end
  end

  // capture register loads only on a qualified beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    capd_q <= '0;
    else if (take) capd_q <= data_i;
  end

  assign mode_o      = mode_q;
  assign cap_valid_o = capv_q;
  assign cap_data_o  = capd_q;
  assign done_o      = done_q;

  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cap_valid_o));

  // R9
  no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o |-> $past(busy_q));

  // R5
  rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !qual_i) |=> (rem_q == $past(rem_q)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(mode_q));

endmodule

// File: rtl/burst_wait_capture.sv
module burst_wait_capture
  import bwc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [$clog2(MAX_WORDS)-1:0] len_m1_i,
  input  logic                         cfg_late_i,
  input  logic                         wait_i,
  input  logic [DATA_W-1:0]            dq_i,
  output logic                         cap_valid_o,
  output logic [DATA_W-1:0]            cap_data_o,
  output logic                         done_o
);

  wait_mode_e        mode;
  logic              qual;
  logic [DATA_W-1:0] beat_data;

  bwc_wait_align #(.DATA_W(DATA_W)) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .wait_i (wait_i),
    .dq_i   (dq_i),
    .mode_i (mode),
    .qual_o (qual),
    .data_o (beat_data)
  );

  bwc_burst_ctrl #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_m1_i    (len_m1_i),
    .cfg_late_i  (cfg_late_i),
    .qual_i      (qual),
    .data_i      (beat_data),
    .mode_o      (mode),
    .cap_valid_o (cap_valid_o),
    .cap_data_o  (cap_data_o),
    .done_o      (done_o)
  );

endmodule

// File: tb/tb_burst_wait_capture.sv
module tb_burst_wait_capture;

  localparam int DW = 16;
  localparam int MW = 256;
  localparam int LW = $clog2(MW);
  localparam int DEPTH = 1024;

  logic          clk, rst_n, start_i, cfg_late_i, wait_i;
  logic [LW-1:0] len_m1_i;
  logic [DW-1:0] dq_i, cap_data_o;
  logic          cap_valid_o, done_o;

  int n_chk, n_bad;
  bit finished;

  bit          exp_v [DEPTH];
  bit          exp_d [DEPTH];
  logic [DW-1:0] exp_w [DEPTH];

  burst_wait_capture #(.DATA_W(DW), .MAX_WORDS(MW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_m1_i(len_m1_i),
    .cfg_late_i(cfg_late_i), .wait_i(wait_i), .dq_i(dq_i),
    .cap_valid_o(cap_valid_o), .cap_data_o(cap_data_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic bit wait_pat(input int kind, input int i);
    case (kind)
      0: return 1'b0;
      1: return (i % 3) == 1;
      default: return (i < 3) || (i >= 7 && i < 10) || (i % 5 == 4);
    endcase
  endfunction

  function automatic logic [DW-1:0] word_of(input int i);
    return DW'(16'hA5C3 ^ (i * 16'h0137));
  endfunction

  task automatic idle_gap(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(cap_valid_o == 1'b0, req, cap_valid_o, 0);
      chk(done_o == 1'b0, req, done_o, 0);
      start_i = 1'b0;
      wait_i  = 1'b1;
      dq_i    = word_of(k + 999);
    end
  endtask

  // one burst; ign_at: iteration of an extra start pulse, flip_at: iteration where cfg inverts
  task automatic run_case(input int len_m1, input bit mode, input int kind,
                          input int ign_at, input int flip_at, input string req);
    bit busy, m, wprev, w;
    int rem, end_it;
    for (int k = 0; k < DEPTH; k++) begin exp_v[k] = 0; exp_d[k] = 0; exp_w[k] = '0; end
    busy = 0; m = mode; rem = 0; end_it = DEPTH; wprev = 1'b1;
    for (int it = 0; it < DEPTH - 4; it++) begin
      @(negedge clk);
      chk(cap_valid_o == exp_v[it], req, cap_valid_o, exp_v[it]);
      if (exp_v[it]) chk(cap_data_o == exp_w[it], req, cap_data_o, exp_w[it]);
      chk(done_o == exp_d[it], req, done_o, exp_d[it]);
      if (it > end_it + 3) break;
      w = wait_pat(kind, it);
      start_i    = (it == 0) || (it == ign_at);
      len_m1_i   = (it == 0) ? LW'(len_m1) : LW'(3);
      cfg_late_i = (it < flip_at) ? mode : ~mode;
      wait_i     = w;
      dq_i       = word_of(it);
      if (it == 0) begin busy = 1; rem = len_m1 + 1; m = mode; end
      if (busy && (m ? !wprev : !w)) begin
        exp_v[it+2] = 1;
        exp_w[it+2] = word_of(it);
        rem--;
        if (rem == 0) begin busy = 0; exp_d[it+3] = 1; end_it = it; end
      end
      wprev = w;
    end
    start_i = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start_i = 0; len_m1_i = '0; cfg_late_i = 1; wait_i = 0; dq_i = '0;
    repeat (3) @(negedge clk);
    chk(cap_valid_o == 0, "R1", cap_valid_o, 0);
    chk(done_o == 0, "R1", done_o, 0);
    rst_n = 1'b1;
    // R9: WAIT low with changing data but no start
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(cap_valid_o == 0, "R9", cap_valid_o, 0);
      chk(done_o == 0, "R9", done_o, 0);
      dq_i = word_of(k);
    end
  endtask

  task automatic test_reset_midburst();
    @(negedge clk);
    start_i = 1; len_m1_i = LW'(20); cfg_late_i = 0; wait_i = 0;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cap_valid_o == 0, "R1", cap_valid_o, 0);
    chk(done_o == 0, "R1", done_o, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(cap_valid_o == 0, "R1", cap_valid_o, 0);
    end
    idle_gap(2, "R9");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    test_reset();
    idle_gap(2, "R9");
    run_case(7, 1'b0, 0, -1, DEPTH, "R2 R5");
    idle_gap(2, "R9");
    run_case(7, 1'b1, 0, -1, DEPTH, "R3 R5");
    idle_gap(2, "R9");
    run_case(15, 1'b0, 1, -1, DEPTH, "R2 R4");
    idle_gap(2, "R9");
    run_case(15, 1'b1, 2, -1, DEPTH, "R3 R4");
    idle_gap(2, "R9");
    run_case(0, 1'b1, 0, -1, DEPTH, "R5 R6");
    idle_gap(2, "R9");
    run_case(0, 1'b0, 1, -1, DEPTH, "R5 R6");
    idle_gap(2, "R9");
    run_case(255, 1'b0, 1, -1, DEPTH, "R5 R6");
    idle_gap(2, "R9");
    run_case(9, 1'b0, 2, 4, DEPTH, "R7");
    idle_gap(2, "R9");
    run_case(9, 1'b1, 1, -1, 2, "R8");
    idle_gap(2, "R9");
    run_case(9, 1'b0, 2, -1, 3, "R8");
    idle_gap(2, "R9");
    test_reset_midburst();
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

endmodule